// File: doc/BRIEF.md
# Serial Page Address Generator

This block produces the internal bank, row and column address for an endless serial burst across a two-bank memory. On an accepted start strobe it loads a start bank, row and column. On every beat where the advance enable is high, the column moves up by one.

When a beat moves past the last column of a row, the column returns to 0 and the address moves to the other bank. The row number increments only when the move is from bank B to bank A. As a result, rows are visited in an interleaved order: row n in A, row n in B, row n+1 in A, and so on. This continues without end until a stop strobe arrives. The stop strobe stands for the all-banks-precharge request.

A start is accepted only while the mode inputs select the special-page burst code with sequential ordering. A one-cycle crossing pulse marks each move to a new row, so a downstream array model can open that row. All outputs are registered.

Top module: `serial_page_addr_gen`

## Requirements
- R1: After reset, `valid_o` and `cross_o` are 0 and `bank_o`, `row_o` and `col_o` are all 0.
- R2: A start strobe is accepted when `mode_len_i` is 3'b110 and `mode_interleave_i` is 0, with no stop in the same cycle. On the next clock edge the outputs show the start bank, row and column, `valid_o` is 1 and `cross_o` is 0.
- R3: A start strobe with any other `mode_len_i` value, or with `mode_interleave_i` = 1, is ignored. Validity and the address outputs keep their values.
- R4: While valid, a beat with `adv_i` = 1 at a column below 255 raises the column by 1 one cycle later. Bank and row do not change.
- R5: While `adv_i` is 0 and no start or stop is applied, bank, row and column hold their values.
- R6: A beat at column 255 in bank A (bank = 0) moves to column 0 of bank B (bank = 1) and keeps the same row.
- R7: A beat at column 255 in bank B moves to column 0 of bank A and raises the row by 1.
- R8: A beat at column 255 of bank B, row 2047, wraps to bank A, row 0, column 0.
- R9: `cross_o` is 1 for exactly the one cycle in which the new row's address first appears, and is 0 in every other cycle.
- R10: A stop strobe clears `valid_o` on the next edge and freezes the address. Later advance beats have no effect. A stop wins over a start in the same cycle.
- R11: An accepted start while a serial access is running restarts the access at the newly supplied address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Serial access start strobe |
| mode_len_i | input | 3 | Burst-length code of the current mode |
| mode_interleave_i | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| start_bank_i | input | 1 | Start bank (0 = A, 1 = B) |
| start_row_i | input | 11 | Start row |
| start_col_i | input | 8 | Start column |
| adv_i | input | 1 | Beat enable; low stalls the address |
| stop_i | input | 1 | All-banks-precharge request; ends the access |
| bank_o | output | 1 | Current bank |
| row_o | output | 11 | Current row |
| col_o | output | 8 | Current column |
| valid_o | output | 1 | Serial access in progress |
| cross_o | output | 1 | One-cycle pulse on each bank/row crossing |

## Verification
The assertions check the following cycle-local rules on every clock:
- loading on an accepted start, and ignoring a start whose mode is wrong;
- the plus-one column step, and holding while stalled;
- the crossing step, which moves to column 0 and adds one to the combined {row, bank} index;
- that the crossing pulse lasts a single cycle;
- that a stop clears the access.

Some behaviour shows only over long runs of beats, so the bench scenarios must cover it. These cover the full interleaved row sequence across several rows, the wrap from the last row of bank B to row 0 of bank A, and whether a stopped access stays frozen under later beats.

// File: rtl/spag_pkg.sv
package spag_pkg;
  localparam int ROW_W        = 11;
  localparam int COL_W        = 8;
  localparam int LEN_W        = 3;
  localparam logic [LEN_W-1:0] SERIAL_LEN_CODE = 3'b110;
endpackage

// File: rtl/spag_mode_gate.sv
module spag_mode_gate
  import spag_pkg::*;
#(
  parameter int                LW   = LEN_W,
  parameter logic [LW-1:0]     CODE = SERIAL_LEN_CODE
) (
  input  logic [LW-1:0] len_code,
  input  logic          interleave,
  output logic          armed
);
  always_comb armed = (len_code == CODE) && !interleave;
endmodule

// File: rtl/spag_col_ctr.sv
module spag_col_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_col,
  input  logic          step,
  output logic [CW-1:0] col,
  output logic          at_end
);
  always_comb at_end = &col;

  always_ff @(posedge clk) begin
    if (rst)       col <= '0;
    else if (load) col <= load_col;
    else if (step) col <= at_end ? '0 : col + 1'b1;
  end
endmodule

// File: rtl/spag_row_stepper.sv
module spag_row_stepper #(
  parameter int RW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          load_bank,
  input  logic [RW-1:0] load_row,
  input  logic          step,
  output logic          bank,
  output logic [RW-1:0] row
);
  localparam int IW = RW + 1;
  // bank is the least significant bit, so one increment toggles the bank
  // and carries into the row only from bank B
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (load) idx <= {load_row, load_bank};
    else if (step) idx <= idx + 1'b1;
  end

  always_comb begin
    bank = idx[0];
    row  = idx[IW-1:1];
  end
endmodule

// File: rtl/serial_page_addr_gen.sv
module serial_page_addr_gen
  import spag_pkg::*;
#(
  parameter int ROW_BITS = ROW_W,
  parameter int COL_BITS = COL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [LEN_W-1:0]    mode_len_i,
  input  logic                mode_interleave_i,
  input  logic                start_bank_i,
  input  logic [ROW_BITS-1:0] start_row_i,
  input  logic [COL_BITS-1:0] start_col_i,
  input  logic                adv_i,
  input  logic                stop_i,
  output logic                bank_o,
  output logic [ROW_BITS-1:0] row_o,
  output logic [COL_BITS-1:0] col_o,
  output logic                valid_o,
  output logic                cross_o
);
  logic armed, do_load, do_step, col_end;
  logic valid_q, cross_q;

  spag_mode_gate u_gate (
    .len_code   (mode_len_i),
    .interleave (mode_interleave_i),
    .armed      (armed)
  );

  always_comb begin
    do_load = start_i && armed && !stop_i;
    do_step = valid_q && adv_i && !stop_i && !do_load;
  end

  spag_col_ctr #(.CW(COL_BITS)) u_col (
    .clk      (clk),
    .rst      (rst),
    .load     (do_load),
    .load_col (start_col_i),
    .step     (do_step),
    .col      (col_o),
    .at_end   (col_end)
  );

  spag_row_stepper #(.RW(ROW_BITS)) u_row (
    .clk       (clk),
    .rst       (rst),
    .load      (do_load),
    .load_bank (start_bank_i),
    .load_row  (start_row_i),
    .step      (do_step && col_end),
    .bank      (bank_o),
    .row       (row_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      cross_q <= 1'b0;
    end else begin
      if (stop_i)       valid_q <= 1'b0;
      else if (do_load) valid_q <= 1'b1;
      cross_q <= do_step && col_end;
    end
  end

  always_comb begin
    valid_o = valid_q;
    cross_o = cross_q;
  end
endmodule

// File: rtl/spag_checker.sv
module spag_checker #(
  parameter int RB = 11,
  parameter int CB = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic [2:0]    mode_len_i,
  input logic          mode_interleave_i,
  input logic          start_bank_i,
  input logic [RB-1:0] start_row_i,
  input logic [CB-1:0] start_col_i,
  input logic          adv_i,
  input logic          stop_i,
  input logic          bank_o,
  input logic [RB-1:0] row_o,
  input logic [CB-1:0] col_o,
  input logic          valid_o,
  input logic          cross_o
);
  logic good_mode, quiet;
  always_comb begin
    good_mode = (mode_len_i == 3'b110) && !mode_interleave_i;
    quiet     = !stop_i && !(start_i && good_mode);
  end

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start_i && good_mode && !stop_i |=> valid_o && !cross_o &&
      bank_o == $past(start_bank_i) && row_o == $past(start_row_i) &&
      col_o == $past(start_col_i));

  // R3
  bad_mode_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    start_i && !good_mode && !stop_i && !valid_o |=> !valid_o &&
      $stable(col_o) && $stable(row_o) && $stable(bank_o));

  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o && adv_i && quiet && !(&col_o) |=>
      col_o == CB'($past(col_o) + 1'b1) && $stable(row_o) && $stable(bank_o));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_i && quiet |=> $stable(col_o) && $stable(row_o) && $stable(bank_o));

  // R6 R7
  row_cross_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o && adv_i && quiet && (&col_o) |=> col_o == '0 && cross_o &&
      {row_o, bank_o} == (RB+1)'($past({row_o, bank_o}) + 1'b1));

  // R9
  cross_single_chk: assert property (@(posedge clk) disable iff (rst)
    cross_o |=> !cross_o);

  // R10
  stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !valid_o && !cross_o);
endmodule

bind serial_page_addr_gen spag_checker #(.RB(ROW_BITS), .CB(COL_BITS)) u_spag_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .mode_len_i(mode_len_i),
  .mode_interleave_i(mode_interleave_i), .start_bank_i(start_bank_i),
  .start_row_i(start_row_i), .start_col_i(start_col_i), .adv_i(adv_i),
  .stop_i(stop_i), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
  .valid_o(valid_o), .cross_o(cross_o)
);

// File: tb/test_serial_page_addr_gen.sv
module test_serial_page_addr_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i, mode_interleave_i, start_bank_i, adv_i, stop_i;
  logic [2:0]  mode_len_i;
  logic [10:0] start_row_i;
  logic [7:0]  start_col_i;
  logic        bank_o, valid_o, cross_o;
  logic [10:0] row_o;
  logic [7:0]  col_o;

  int checks = 0, errors = 0;
  logic        m_valid, m_bank, m_cross;
  logic [10:0] m_row;
  logic [7:0]  m_col;

  always #2 clk = ~clk;

  serial_page_addr_gen i_serial_page_addr_gen (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_len_i(mode_len_i),
    .mode_interleave_i(mode_interleave_i), .start_bank_i(start_bank_i),
    .start_row_i(start_row_i), .start_col_i(start_col_i), .adv_i(adv_i),
    .stop_i(stop_i), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
    .valid_o(valid_o), .cross_o(cross_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " valid"}, 32'(valid_o), 32'(m_valid));
    chk({tag, " bank"},  32'(bank_o),  32'(m_bank));
    chk({tag, " row"},   32'(row_o),   32'(m_row));
    chk({tag, " col"},   32'(col_o),   32'(m_col));
    chk({tag, " cross"}, 32'(cross_o), 32'(m_cross));
  endtask

  // expected next state from the requirements
  task automatic model_tick();
    logic [11:0] k;
    if (rst) begin
      m_valid = 0; m_bank = 0; m_row = 0; m_col = 0; m_cross = 0;
    end else if (stop_i) begin
      m_valid = 0; m_cross = 0;
    end else if (start_i && mode_len_i == 3'b110 && !mode_interleave_i) begin
      m_valid = 1; m_bank = start_bank_i; m_row = start_row_i;
      m_col = start_col_i; m_cross = 0;
    end else if (m_valid && adv_i) begin
      if (m_col == 8'd255) begin
        k = {m_row, m_bank} + 12'd1;
        m_row = k[11:1]; m_bank = k[0]; m_col = 0; m_cross = 1;
      end else begin
        m_col = m_col + 8'd1; m_cross = 0;
      end
    end else m_cross = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_tick();
    @(negedge clk);
  endtask

  task automatic idle_in();
    start_i = 0; stop_i = 0; adv_i = 0;
    mode_len_i = 3'b110; mode_interleave_i = 0;
  endtask

  task automatic do_start(input logic b, input logic [10:0] r, input logic [7:0] c);
    start_i = 1; start_bank_i = b; start_row_i = r; start_col_i = c;
    tick();
    start_i = 0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle_in();
    start_bank_i = 0; start_row_i = 0; start_col_i = 0;
    rst = 1;
    tick(); tick();
    rst = 0;
    chk_all("R1 reset");

    // R3: wrong length code, then interleaved ordering
    mode_len_i = 3'b111; do_start(1, 11'd9, 8'd9);
    chk_all("R3 bad length");
    mode_len_i = 3'b110; mode_interleave_i = 1; do_start(1, 11'd9, 8'd9);
    chk_all("R3 interleave");
    mode_interleave_i = 0;

    // R2 load, R4 step
    do_start(0, 11'd5, 8'd254);
    chk_all("R2 load");
    adv_i = 1; tick(); chk_all("R4 step");
    // R6 A->B, R9 pulse
    tick(); chk_all("R6 A to B");
    chk("R9 pulse high", 32'(cross_o), 32'd1);
    tick(); chk("R9 pulse single", 32'(cross_o), 32'd0);
    // R5 hold
    adv_i = 0; tick(); tick(); chk_all("R5 hold");
    // R7 B->A row+1
    adv_i = 1;
    for (int i = 0; i < 255; i++) tick();
    chk_all("R7 B to A");
    chk("R7 row", 32'(row_o), 32'd6);
    // R8 wrap
    do_start(1, 11'd2047, 8'd255);
    tick(); chk_all("R8 wrap");
    chk("R8 row zero", 32'(row_o), 32'd0);
    // R11 restart while running
    do_start(1, 11'd100, 8'd17); chk_all("R11 restart");
    // R10 stop wins over start, then frozen
    adv_i = 1; stop_i = 1; start_i = 1; start_row_i = 11'd3; tick();
    stop_i = 0; start_i = 0; chk_all("R10 stop");
    tick(); tick(); chk_all("R10 frozen");

    // random mix
    for (int i = 0; i < 6000; i++) begin
      start_i = ($urandom_range(0, 99) < 3);
      mode_len_i = ($urandom_range(0, 9) == 0) ? 3'($urandom) : 3'b110;
      mode_interleave_i = ($urandom_range(0, 9) == 0);
      start_bank_i = 1'($urandom);
      start_row_i = ($urandom_range(0, 3) == 0) ? 11'd2047 : 11'($urandom);
      start_col_i = 8'($urandom_range(240, 255));
      adv_i = ($urandom_range(0, 9) < 8);
      stop_i = ($urandom_range(0, 199) == 0);
      tick();
      chk_all("R4 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule